// File: doc/BRIEF.md
# Transmitter Power-Down and Lock-Wait Sequencer

This block decides when a serial transmitter may drive its lanes. A power control input, active high, keeps the transmitter off while it is low. When it is off, the lane drivers are in high impedance and the output termination is disconnected. When the input goes high, the termination is connected straight away. A lock timer then counts a fixed number of frames, where one frame is one period of the parallel word clock. This timer takes the place of a real lock detector. Only after the timer expires are the lanes switched from high impedance to active drive.

The block is clocked at the serial slot rate. An internal slot counter marks the frame boundaries. A frame is 9 slots in balanced-coding mode (seven data slots and two code slots) or 7 slots in plain mode. The mode is captured when the release is seen and is held until the next power cycle. Drive enable and the locked flag rise on a frame boundary. A load strobe then marks the first slot of every frame, so the parallel data path starts on a whole word. Driving the power input low at any point returns the block to the off state on the next clock edge. A later release always starts the full lock interval again from zero.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `term_en`, `lane_en`, `locked` and `frame_load` are all 0.
- R2: While `pwr_on` is low, `term_en`, `lane_en`, `locked` and `frame_load` stay 0. This means the termination is off and the lanes are high impedance.
- R3: When a clock edge samples `pwr_on` high while the block is off, `term_en` is 1 and `lane_en` is 0 in the following cycle.
- R4: After `term_en` rises, `lane_en` stays 0 for exactly LOCK_FRAMES × L cycles and then rises. L is the frame length in slots.
- R5: L is 9 when `bal_mode` is 1 and 7 when `bal_mode` is 0, sampled at the edge that sees the release. Changes to `bal_mode` after that edge have no effect until the next power cycle.
- R6: `frame_load` is 1 in the first cycle that `lane_en` is 1, and again every L cycles after that. It is 0 at all other times.
- R7: If an edge samples `pwr_on` low in any state, including partway through the lock wait, all four outputs are 0 in the next cycle.
- R8: Each new release restarts the lock count from zero. A release after an aborted lock wait still waits the full LOCK_FRAMES × L cycles.
- R9: `lane_en` is never 1 while `term_en` is 0.
- R10: `locked` always equals `lane_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power control, synchronous to `clk`; low means powered down |
| bal_mode | input | 1 | 1 selects the 9-slot balanced frame, 0 the 7-slot plain frame |
| term_en | output | 1 | Output termination connected |
| lane_en | output | 1 | Lanes driven (0 means high impedance) |
| locked | output | 1 | Lock interval complete |
| frame_load | output | 1 | First slot of a frame while lanes are driven |

## Verification
The bench measures the exact length of the lock wait in both frame modes, with `bal_mode` toggling on every cycle of the wait. A design that sampled the mode late, or let it change mid-wait, would give a length other than LOCK_FRAMES × 7 or × 9. The bench also aborts the wait partway and then releases again. A design that kept its partial count would enable the lanes early. A design that left the termination or drive on after the abort would show nonzero outputs on the next cycle. The spacing of `frame_load` is compared against a cycle-count model, which catches enables that come off a frame boundary or strobes that repeat at the wrong period.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF     = 2'd0,
        PS_LOCKING = 2'd1,
        PS_ACTIVE  = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/frame_slot_ctr.sv
module frame_slot_ctr #(
    parameter int SHORT_LEN = 7,
    parameter int LONG_LEN  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic long_sel,
    output logic frame_end,
    output logic at_first
);
    localparam int SW = $clog2(LONG_LEN);
    localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_LEN - 1);
    localparam logic [SW-1:0] LONG_LAST  = SW'(LONG_LEN - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic          is_long;
    } slot_regs_t;

    slot_regs_t r_d, r_q;
    logic [SW-1:0] last_slot;

    always_comb begin
        last_slot = r_q.is_long ? LONG_LAST : SHORT_LAST;
        frame_end = !hold && (r_q.slot == last_slot);
        at_first  = (r_q.slot == '0);
        r_d = r_q;
        if (hold) begin
            r_d.slot    = '0;
            r_d.is_long = long_sel;
        end else if (frame_end) begin
            r_d.slot = '0;
        end else begin
            r_d.slot = r_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // frame length stays inside the selected mode
    p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.is_long |-> (r_q.slot <= SHORT_LAST));
    p_mode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> $stable(r_q.is_long));
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
    parameter int LOCK_FRAMES = 32800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int LW = $clog2(LOCK_FRAMES + 1);
    localparam logic [LW-1:0] FINAL = LW'(LOCK_FRAMES - 1);
    localparam logic [LW-1:0] LIMIT = LW'(LOCK_FRAMES);

    typedef struct packed {
        logic [LW-1:0] cnt;
    } lock_regs_t;

    lock_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        done = !clear && tick && (r_q.cnt == FINAL);
        if (clear)
            r_d.cnt = '0;
        else if (tick && (r_q.cnt != LIMIT))
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LIMIT);
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (r_q.cnt == '0));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int LOCK_FRAMES = 32800,
    parameter int SHORT_LEN   = 7,
    parameter int LONG_LEN    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic bal_mode,
    output logic term_en,
    output logic lane_en,
    output logic locked,
    output logic frame_load
);
    typedef struct packed {
        pwr_state_e st;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic slot_hold, frame_end, at_first;
    logic timer_clear, lock_done;

    frame_slot_ctr #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (slot_hold),
        .long_sel  (bal_mode),
        .frame_end (frame_end),
        .at_first  (at_first)
    );

    lock_timer #(.LOCK_FRAMES(LOCK_FRAMES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .tick  (frame_end),
        .done  (lock_done)
    );

    always_comb begin
        slot_hold   = (r_q.st == PS_OFF);
        timer_clear = (r_q.st != PS_LOCKING);
        r_d = r_q;
        if (!pwr_on) begin
            r_d.st = PS_OFF;
        end else begin
            case (r_q.st)
                PS_OFF:     r_d.st = PS_LOCKING;
                PS_LOCKING: if (lock_done) r_d.st = PS_ACTIVE;
                PS_ACTIVE:  r_d.st = PS_ACTIVE;
                default:    r_d.st = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PS_OFF};
        else        r_q <= r_d;
    end

    assign term_en    = (r_q.st == PS_LOCKING) || (r_q.st == PS_ACTIVE);
    assign lane_en    = (r_q.st == PS_ACTIVE);
    assign locked     = lane_en;
    assign frame_load = lane_en && at_first;

    p_lane_needs_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lane_en |-> term_en);
    p_pd_forces_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (!term_en && !lane_en && !frame_load));
    p_release_term_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_en && pwr_on) |=> (term_en && !lane_en));
    p_drive_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_en) |-> frame_load);
    p_drive_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_en) |-> $past(term_en));
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int NF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on = 1'b0;
    logic bal_mode = 1'b0;
    logic term_en, lane_en, locked, frame_load;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_run = 1'b0;

    // cycle-count reference
    bit m_on = 1'b0;
    int m_cnt = 0;
    int m_len = 7;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(.LOCK_FRAMES(NF)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .bal_mode(bal_mode),
        .term_en(term_en), .lane_en(lane_en), .locked(locked),
        .frame_load(frame_load)
    );

    function automatic bit exp_lane(bit on, int cnt, int len);
        return on && (cnt >= NF * len);
    endfunction

    function automatic bit exp_load(bit on, int cnt, int len);
        return exp_lane(on, cnt, len) && (((cnt - NF * len) % len) == 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on = 1'b0;
        end else if (!pwr_on) begin
            m_on = 1'b0;
        end else if (!m_on) begin
            m_on  = 1'b1;
            m_cnt = 0;
            m_len = bal_mode ? 9 : 7;
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    task automatic check(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // continuous per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            if (!m_on) check("R2 outputs off", {term_en, lane_en, locked, frame_load}, 0);
            else begin
                check("R3 term_en", term_en, 1);
                check("R4 lane_en", lane_en, exp_lane(m_on, m_cnt, m_len));
                check("R6 frame_load", frame_load, exp_load(m_on, m_cnt, m_len));
            end
            check("R10 locked", locked, lane_en);
            check("R9 lane implies term", (lane_en && !term_en) ? 1 : 0, 0);
        end
    end

    task automatic measure_wait(bit mode, string req, output int n);
        @(negedge clk);
        bal_mode = mode;
        pwr_on   = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            if (lane_en) break;
            n++;
            bal_mode = ~bal_mode;
        end
        check(req, n, NF * (mode ? 9 : 7));
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n, gap;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check("R1 in reset", {term_en, lane_en, locked, frame_load}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {term_en, lane_en, locked, frame_load}, 0);
        repeat (10) @(negedge clk);

        // R5 balanced frame length with bal_mode toggling
        measure_wait(1'b1, "R5 R4 wait length 9-slot", n);
        check("R6 load at enable", frame_load, 1);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!frame_load);
        check("R6 frame period", gap, 9);

        // R7 abort mid-lock, then R8 full restart
        @(negedge clk); pwr_on = 1'b0;
        @(negedge clk);
        check("R7 off after drop", {term_en, lane_en}, 0);
        @(negedge clk); pwr_on = 1'b1; bal_mode = 1'b0;
        repeat (NF * 7 / 2) @(negedge clk);
        pwr_on = 1'b0;
        @(negedge clk);
        check("R7 abort mid-lock", {term_en, lane_en, locked, frame_load}, 0);
        measure_wait(1'b0, "R8 R5 full restart 7-slot", n);

        // random phase
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (($urandom % 100) < 8) pwr_on = ~pwr_on;
            if (($urandom % 100) < 30) bal_mode = $urandom % 2;
            if (!pwr_on && ($urandom % 100) < 20) pwr_on = 1'b1;
        end
        for (int i = 0; i < 120; i++) @(negedge clk);

        done_run = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule